// File: doc/BRIEF.md
# Bus Write FIFO Status Sequencer

This block drives three status flags that imitate how a posted-write FIFO on an expansion bus fills and drains. Each write strobe starts a staggered ripple. The input flag goes high at once. The middle flag rises later, and the output flag rises after that. Every flag has a fixed high period, and each one is timed by its own rise deadline and fall deadline.

A write that arrives while a ripple is already running does not move any pending rise. It pushes each pending fall deadline back by that flag's full high period, so a burst of writes keeps the flags high for longer. The fall deadline counters saturate: once a deadline is at the counter's largest value, further writes cannot push it any later.

All timing is counted in clock cycles. The flags appear in a fixed-width status word, and every other bit of that word is zero.

Top module: `bus_wfifo_status`

## Requirements
- R1: A write accepted at clock edge t sets status bit 5 at edge t. Bit 5 stays high until edge t+T_IN_HIGH (default 60), where it clears if no further write arrives.
- R2: A write accepted at edge t with no middle rise pending schedules bit 4 to rise at edge t+T_MID_RISE (default 60). When no fall is pending, bit 4 falls T_MID_HIGH (default 160) edges after that rise.
- R3: A write accepted at edge t with no output rise pending schedules bit 0 to rise at edge t+T_OUT_RISE (default 120). When no fall is pending, bit 0 falls T_OUT_HIGH (default 420) edges after that rise.
- R4: A write that arrives while a flag's fall is still pending (the fall edge is this edge or later) moves that fall later by the flag's full high period, and does not restart it.
- R5: A write that arrives while a rise of bit 4 or bit 0 is pending leaves that rise edge unchanged.
- R6: Deadline counters are CNT_W bits wide, and the all-ones value means idle. An extended fall lands no later than 2^CNT_W-2 edges after the write, so further writes at the cap add nothing.
- R7: Every status bit other than bits 5, 4 and 0 reads as zero.
- R8: While reset (active high, synchronous) is asserted, the status word is zero and every timer is idle. After reset is released, no flag rises until a write arrives.
- R9: If a flag's rise and fall fall due on the same edge, the fall is applied last and the flag ends low. With no write pending in any window, the status word stays zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_i | input | 1 | One-cycle strobe for each accepted bus write |
| status_o | output | STATUS_W | Status word; bit 5 is the input flag, bit 4 the middle flag, bit 0 the output flag |

## Verification
The bench builds the block with CNT_W set to 10, so the idle code is 1023 and the fall cap sits 1022 edges past the write. A short burst of back-to-back writes therefore drives the output flag's deadline into saturation, which lets the bench watch the cap hold and then drain. All other timing parameters keep their defaults. As a result, the single-write ripple, overlapping extensions and random write traffic all run at their real offsets, and each phase finishes within a couple of thousand cycles.

// File: rtl/wfs_pkg.sv
`timescale 1ns/1ps
package wfs_pkg;
  // How an armed deadline reacts when it is already pending
  typedef enum logic {
    UPD_EXTEND = 1'b0,  // push the deadline later by the extension amount
    UPD_KEEP   = 1'b1   // leave the pending deadline untouched
  } upd_mode_e;
endpackage

// File: rtl/deadline_timer.sv
`timescale 1ns/1ps
module deadline_timer #(
  parameter int                 CNT_W = 12,
  parameter wfs_pkg::upd_mode_e MODE  = wfs_pkg::UPD_EXTEND
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] ext_val,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pending_o,
  output logic             fire_o
);
  localparam logic [CNT_W-1:0] IDLE = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] SAT  = IDLE - CNT_W'(1);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             idle;
  logic             do_ext;
  logic [CNT_W:0]   ext_sum;
  logic [CNT_W-1:0] ext_sat;

  assign idle    = (cnt_q == IDLE);
  assign do_ext  = arm && !idle && (MODE == wfs_pkg::UPD_EXTEND);
  assign ext_sum = {1'b0, cnt_q} - (CNT_W+1)'(1) + {1'b0, ext_val};
  assign ext_sat = (ext_sum >= {1'b0, IDLE}) ? SAT : ext_sum[CNT_W-1:0];

  assign fire_o    = !idle && (cnt_q == ONE) && !do_ext;
  assign pending_o = !idle;
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= IDLE;
    end else if (arm && idle) begin
      cnt_q <= load_val;
    end else if (do_ext) begin
      cnt_q <= ext_sat;
    end else if (fire_o) begin
      cnt_q <= IDLE;
    end else if (!idle) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  // An armed timer that is not firing this edge is pending afterwards
  assert_armed_pending_R6 : assert property (@(posedge clk) disable iff (rst)
    (arm && cnt_q != ONE) |=> (cnt_q != IDLE));

  generate
    if (MODE == wfs_pkg::UPD_EXTEND) begin : g_ext_chk
      // A write during a pending fall never pulls the deadline earlier
      assert_extend_grows_R4 : assert property (@(posedge clk) disable iff (rst)
        (arm && cnt_q != IDLE) |=> (cnt_q >= $past(cnt_q)));
    end else begin : g_keep_chk
      // A write during a pending rise leaves the countdown on course
      assert_rise_kept_R5 : assert property (@(posedge clk) disable iff (rst)
        (arm && cnt_q != IDLE && cnt_q != ONE) |=> (cnt_q == $past(cnt_q) - ONE));
    end
  endgenerate
endmodule

// File: rtl/flag_stage.sv
`timescale 1ns/1ps
module flag_stage #(
  parameter int CNT_W    = 12,
  parameter bit HAS_RISE = 1'b1,
  parameter int RISE_T   = 60,
  parameter int HIGH_T   = 160
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  output logic flag_o
);
  localparam logic [CNT_W-1:0] IDLE   = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] SAT    = IDLE - CNT_W'(1);
  localparam logic [CNT_W-1:0] HIGH_V = CNT_W'(HIGH_T);

  logic             rise_evt;
  logic             fall_evt;
  logic             off_pending;
  logic [CNT_W-1:0] off_load;
  logic [CNT_W-1:0] off_cnt;
  logic             flag_q;

  generate
    if (HAS_RISE) begin : g_rise
      localparam logic [CNT_W-1:0] RISE_V  = CNT_W'(RISE_T);
      localparam logic [CNT_W-1:0] FIRST_V = CNT_W'(RISE_T + HIGH_T);
      logic [CNT_W-1:0] rise_cnt;
      logic             rise_pending;
      logic [CNT_W:0]   chain_sum;

      deadline_timer #(.CNT_W(CNT_W), .MODE(wfs_pkg::UPD_KEEP)) u_rise (
        .clk       (clk),
        .rst       (rst),
        .arm       (arm),
        .load_val  (RISE_V),
        .ext_val   (RISE_V),
        .cnt_o     (rise_cnt),
        .pending_o (rise_pending),
        .fire_o    (rise_evt)
      );

      // Fall is scheduled relative to the rise that will actually occur
      assign chain_sum = {1'b0, rise_cnt} - (CNT_W+1)'(1) + {1'b0, HIGH_V};
      always_comb begin
        if (!rise_pending)              off_load = FIRST_V;
        else if (chain_sum >= {1'b0, IDLE}) off_load = SAT;
        else                            off_load = chain_sum[CNT_W-1:0];
      end
    end else begin : g_now
      assign rise_evt = arm;
      assign off_load = HIGH_V;
    end
  endgenerate

  deadline_timer #(.CNT_W(CNT_W), .MODE(wfs_pkg::UPD_EXTEND)) u_fall (
    .clk       (clk),
    .rst       (rst),
    .arm       (arm),
    .load_val  (off_load),
    .ext_val   (HIGH_V),
    .cnt_o     (off_cnt),
    .pending_o (off_pending),
    .fire_o    (fall_evt)
  );

  // Rise applied first, fall last: a coincident pair leaves the flag low
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
    end else begin
      if (rise_evt) flag_q <= 1'b1;
      if (fall_evt) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;

  // A high flag always has a fall scheduled
  assert_flag_has_fall_R2 : assert property (@(posedge clk) disable iff (rst)
    flag_q |-> off_pending);

  // A flag only rises from its own rise event, never spontaneously
  assert_rise_from_event_R8 : assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(rise_evt));

  // A flag only drops when its fall deadline expires
  assert_fall_from_deadline_R9 : assert property (@(posedge clk) disable iff (rst)
    $fell(flag_q) |-> $past(fall_evt));

  // The fall counter never holds the idle code while the flag is high
  assert_fall_not_idle_R6 : assert property (@(posedge clk) disable iff (rst)
    flag_q |-> (off_cnt != IDLE));
endmodule

// File: rtl/bus_wfifo_status.sv
`timescale 1ns/1ps
module bus_wfifo_status #(
  parameter int STATUS_W   = 32,
  parameter int CNT_W      = 12,
  parameter int POS_IN     = 5,
  parameter int POS_MID    = 4,
  parameter int POS_OUT    = 0,
  parameter int T_IN_HIGH  = 60,
  parameter int T_MID_RISE = 60,
  parameter int T_MID_HIGH = 160,
  parameter int T_OUT_RISE = 120,
  parameter int T_OUT_HIGH = 420
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr_i,
  output logic [STATUS_W-1:0] status_o
);
  localparam int NUM_FLAGS = 3;
  localparam logic [STATUS_W-1:0] FLAG_MASK =
    (STATUS_W'(1) << POS_IN) | (STATUS_W'(1) << POS_MID) | (STATUS_W'(1) << POS_OUT);

  logic [NUM_FLAGS-1:0] flags;

  flag_stage #(.CNT_W(CNT_W), .HAS_RISE(1'b0), .RISE_T(0), .HIGH_T(T_IN_HIGH)) u_in (
    .clk (clk), .rst (rst), .arm (bus_wr_i), .flag_o (flags[0])
  );

  flag_stage #(.CNT_W(CNT_W), .HAS_RISE(1'b1), .RISE_T(T_MID_RISE), .HIGH_T(T_MID_HIGH)) u_mid (
    .clk (clk), .rst (rst), .arm (bus_wr_i), .flag_o (flags[1])
  );

  flag_stage #(.CNT_W(CNT_W), .HAS_RISE(1'b1), .RISE_T(T_OUT_RISE), .HIGH_T(T_OUT_HIGH)) u_out (
    .clk (clk), .rst (rst), .arm (bus_wr_i), .flag_o (flags[2])
  );

  always_comb begin
    status_o          = '0;
    status_o[POS_IN]  = flags[0];
    status_o[POS_MID] = flags[1];
    status_o[POS_OUT] = flags[2];
  end

  // A write sets the input flag on the same edge
  assert_in_flag_on_write_R1 : assert property (@(posedge clk) disable iff (rst)
    bus_wr_i |=> status_o[POS_IN]);

  // No write activity while every flag is low keeps the word clear
  assert_quiet_stays_clear_R9 : assert property (@(posedge clk) disable iff (rst)
    (status_o == '0 && !bus_wr_i && $past(status_o) == '0 && !$past(bus_wr_i))
      |=> ((status_o & ~FLAG_MASK) == '0));
endmodule

// File: tb/bus_wfifo_status_tb.sv
`timescale 1ns/1ps
module bus_wfifo_status_tb;
  localparam int CNT_W = 10;
  localparam int CAP   = (1 << CNT_W) - 2;
  localparam int SW    = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr  = 1'b0;
  logic [SW-1:0] status;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Reference deadlines in absolute edge numbers; -1 is idle
  int t;
  int d5f, d4r, d4f, d0r, d0f;
  bit e5, e4, e0;

  always #4 clk = ~clk;

  bus_wfifo_status #(.STATUS_W(SW), .CNT_W(CNT_W)) u_dut (
    .clk (clk), .rst (rst), .bus_wr_i (wr), .status_o (status)
  );

  function automatic int capd(int d, int now);
    return (d > now + CAP) ? now + CAP : d;
  endfunction

  task automatic model_reset();
    d5f = -1; d4r = -1; d4f = -1; d0r = -1; d0f = -1;
    e5 = 0; e4 = 0; e0 = 0;
  endtask

  task automatic model_edge(input bit w);
    if (w) begin
      d5f = (d5f < t) ? t + 60 : capd(d5f + 60, t);
      if (d4r < t) d4r = t + 60;
      d4f = (d4f < t) ? d4r + 160 : capd(d4f + 160, t);
      if (d0r < t) d0r = t + 120;
      d0f = (d0f < t) ? d0r + 420 : capd(d0f + 420, t);
      e5 = 1;
    end
    if (d5f == t) begin e5 = 0; d5f = -1; end
    if (d4r == t) begin e4 = 1; d4r = -1; end
    if (d4f == t) begin e4 = 0; d4f = -1; end
    if (d0r == t) begin e0 = 1; d0r = -1; end
    if (d0f == t) begin e0 = 0; d0f = -1; end
  endtask

  task automatic cmp(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at edge %0d: got %0b expected %0b", tag, what, t, act, exp);
    end
  endtask

  task automatic check_word(input string t5, input string t4, input string t0);
    cmp(t5, "bit5", status[5], e5);
    cmp(t4, "bit4", status[4], e4);
    cmp(t0, "bit0", status[0], e0);
    checks++;
    if ((status & ~32'h31) !== '0) begin
      errors++;
      $display("FAIL R7 other bits at edge %0d: got %h expected 0", t, status & ~32'h31);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, sample at the next falling edge
  task automatic step(input bit w, input string t5, input string t4, input string t0);
    wr = w;
    t++;
    model_edge(w);
    @(negedge clk);
    wr = 1'b0;
    check_word(t5, t4, t0);
  endtask

  task automatic idle_run(input int n, input string t5, input string t4, input string t0);
    for (int i = 0; i < n; i++) step(1'b0, t5, t4, t0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    model_reset();
    cmp("R8", "bit5 in reset", status[5], 1'b0);
    cmp("R8", "bit4 in reset", status[4], 1'b0);
    cmp("R8", "bit0 in reset", status[0], 1'b0);
    rst = 1'b0;
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd20240607);
    t = 0;
    model_reset();
    @(negedge clk);
    do_reset();

    // R9: idle after reset, nothing moves
    idle_run(50, "R9", "R9", "R9");

    // R1 R2 R3: lone write, full ripple
    step(1'b1, "R1", "R2", "R3");
    idle_run(600, "R1", "R2", "R3");

    // R4 R5: second write while rises and falls are pending
    step(1'b1, "R4", "R5", "R5");
    idle_run(9, "R4", "R5", "R5");
    step(1'b1, "R4", "R5", "R4");
    idle_run(30, "R4", "R5", "R4");
    step(1'b1, "R4", "R4", "R4");
    idle_run(900, "R4", "R4", "R4");

    // R6: burst drives the fall deadlines into the cap
    for (int i = 0; i < 8; i++) step(1'b1, "R6", "R6", "R6");
    idle_run(1100, "R6", "R6", "R6");

    // R4: constrained random sparse writes
    for (int i = 0; i < 3000; i++) step(($urandom % 40) == 0, "R4", "R4", "R4");
    // R4: denser random writes
    for (int i = 0; i < 400; i++) step(($urandom % 6) == 0, "R6", "R4", "R6");
    idle_run(1200, "R4", "R4", "R4");

    // R8: reset in the middle of a ripple, then silence
    step(1'b1, "R1", "R2", "R3");
    idle_run(130, "R1", "R2", "R3");
    do_reset();
    idle_run(700, "R8", "R8", "R8");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired at edge %0d: got running expected finished", t);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule